// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block stores packets that arrive from the host on one host-to-device endpoint until the CPU has taken them. It has one slot, or two when double buffering is switched on, so that a second packet can land while firmware is still draining the first. The USB-side receive logic marks the start of each packet, streams bytes in, and then either commits the packet as good or abandons it. An isochronous flag selects what happens when no slot is free: the packet is silently dropped, or it is refused with a NAK request.

On the CPU side, a combinational data port always shows the next unread byte of the presented packet, and each read strobe consumes one byte. A ready flag, a byte count and a full indication describe the buffer. Firmware clears the ready flag to hand a slot back. A waiting second packet then takes its place on the next cycle and raises a new interrupt pulse. An optional automatic release hands the slot back as soon as a programmed maximum packet size has been consumed.

Top module: `usb_rxbuf`

## Requirements
- R1: While `pkt_rdy` is 1 and unread bytes remain, `cpu_rdata` shows the next byte of the presented packet in arrival order, and a cycle with `cpu_rd` high consumes it so that the following byte is shown from the next cycle on.
- R2: `pkt_rdy` goes to 1 in the cycle after a commit makes a packet available to an empty CPU side. In that same cycle `irq` pulses for exactly one cycle if `cfg_irq_en` was 1 at the commit edge. `irq` never pulses while `pkt_rdy` is 0, and all outputs are 0 after reset.
- R3: `pkt_cnt` gives the number of stored bytes of the presented packet, including 0 for a zero-length packet, and reads 0 while `pkt_rdy` is 0.
- R4: A cycle with `cpu_clr_rdy` high while `pkt_rdy` is 1 releases the presented slot. The read position then restarts at 0 for the next packet, and a freed slot accepts a new packet.
- R5: With double buffering, if a second packet is stored when the first is released, `pkt_rdy` stays 1 and shows the second packet from the next cycle on, with a fresh one-cycle `irq` pulse when interrupts are enabled.
- R6: `buf_full` is 1 exactly while two committed packets are held.
- R7: With `cfg_autoclear` at 1, the read that consumes byte number `cfg_max_pkt` of a packet releases it as if `cpu_clr_rdy` had been raised. A packet shorter than `cfg_max_pkt` stays presented until cleared.
- R8: With `usb_iso` at 1, a start strobe that finds no free slot is dropped. `usb_drop` pulses for one cycle in the cycle after the strobe, and nothing stored or presented changes.
- R9: With `usb_iso` at 0, a start strobe that finds no free slot is refused. `usb_nak` pulses for one cycle in the cycle after the strobe, and stored data, counts and flags stay unchanged.
- R10: A packet ended with `usb_pkt_abort`, or cut short by a new start strobe, is discarded and leaves its slot free. On the USB side, start takes precedence over abort, abort over commit, and commit over a byte in the same cycle.
- R11: A read strobe after all bytes of the presented packet have been consumed does not move the read position, and `cpu_rdata` reads 0 while no unread byte is shown.
- R12: With `cfg_dbl_buf` at 0, at most one packet is held. A second packet is refused (R8/R9) until the first is released, and `buf_full` stays 0.
- R13: Bytes beyond `MAX_BYTES` in one packet are ignored, so the committed count is capped at `MAX_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| usb_pkt_start | input | 1 | Start of an incoming packet |
| usb_byte_valid | input | 1 | `usb_byte` carries a received byte |
| usb_byte | input | DATA_W | Received byte |
| usb_pkt_commit | input | 1 | Packet ended with a good check, keep it |
| usb_pkt_abort | input | 1 | Packet ended badly, discard it |
| usb_iso | input | 1 | Endpoint is isochronous (drop rather than refuse) |
| usb_nak | output | 1 | One-cycle request to answer NAK |
| usb_drop | output | 1 | One-cycle notice of a dropped isochronous packet |
| cfg_dbl_buf | input | 1 | Enable the second slot |
| cfg_autoclear | input | 1 | Enable release after `cfg_max_pkt` reads |
| cfg_irq_en | input | 1 | Enable the interrupt pulse |
| cfg_max_pkt | input | CNT_W | Maximum packet size for automatic release |
| cpu_rd | input | 1 | Consume one byte |
| cpu_rdata | output | DATA_W | Next unread byte, or 0 |
| cpu_clr_rdy | input | 1 | Firmware release of the presented packet |
| pkt_rdy | output | 1 | A packet is presented to the CPU |
| pkt_cnt | output | CNT_W | Size in bytes of the presented packet |
| buf_full | output | 1 | Both slots hold packets |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench concentrates on the hand-over from one slot to the other. It releases a packet while a second waits and checks that the second appears one cycle later with a new interrupt. A design that lost the pending packet, or raised no second pulse, would leave firmware waiting. It checks that a start strobe which finds both slots taken never disturbs stored bytes or counts. A design that wrote into an occupied slot would corrupt data that the CPU has not yet read. Automatic release is driven with packets longer and shorter than the programmed size. Reads are continued past the end of a packet, and oversized and aborted packets are mixed in. An off-by-one in the release point or the byte cap would show up as a wrong count, a stale byte or a packet presented too long.

// File: rtl/usb_rxbuf_pkg.sv
// Shared types for the USB OUT receive buffer.
// Assumes exactly two slots; a slot index is therefore one bit wide.
package usb_rxbuf_pkg;

    localparam int NUM_SLOTS = 2;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef logic [SLOT_W-1:0] slot_idx_t;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RECV = 1'b1
    } fill_state_e;

    // Slot that follows cur; single buffering always uses slot 0.
    function automatic slot_idx_t next_slot(input logic dbl, input slot_idx_t cur);
        return dbl ? slot_idx_t'(cur + 1'b1) : slot_idx_t'(0);
    endfunction

endpackage

// File: rtl/usb_rxbuf_store.sv
// Packet storage: one byte array and one length register per slot.
// Assumes the write side only targets free slots; the arrays carry no reset,
// and the lengths reset to zero.
module usb_rxbuf_store
    import usb_rxbuf_pkg::*;
#(
    parameter int MAX_BYTES = 64,
    parameter int DATA_W    = 8,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int ADR_W    = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  slot_idx_t         wr_slot,
    input  logic [ADR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  slot_idx_t         commit_slot,
    input  logic [CNT_W-1:0]  commit_len,
    input  slot_idx_t         rd_slot,
    input  logic [ADR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_byte,
    output logic [CNT_W-1:0]  rd_len
);

    logic [DATA_W-1:0] slot_byte [NUM_SLOTS];
    logic [CNT_W-1:0]  slot_len  [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [DATA_W-1:0] mem [MAX_BYTES];
        logic [CNT_W-1:0]  len_q;

        // Store an incoming byte addressed to this slot.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == slot_idx_t'(s))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        // Latch the final byte count when this slot's packet is committed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_q <= '0;
            end else if (commit && (commit_slot == slot_idx_t'(s))) begin
                len_q <= commit_len;
            end
        end

        assign slot_byte[s] = mem[rd_addr];
        assign slot_len[s]  = len_q;
    end

    assign rd_byte = slot_byte[rd_slot];
    assign rd_len  = slot_len[rd_slot];

endmodule

// File: rtl/usb_rxbuf_fill.sv
// USB-side fill control: accepts or refuses a packet at its start strobe,
// writes its bytes into the chosen slot and commits or discards it.
// Assumes slots fill in rotation, so the next slot in turn is the only
// candidate; precedence in a cycle is start, abort, commit, byte.
module usb_rxbuf_fill
    import usb_rxbuf_pkg::*;
#(
    parameter int MAX_BYTES = 64,
    parameter int DATA_W    = 8,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int ADR_W    = $clog2(MAX_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dbl_en,
    input  logic                 usb_pkt_start,
    input  logic                 usb_byte_valid,
    input  logic [DATA_W-1:0]    usb_byte,
    input  logic                 usb_pkt_commit,
    input  logic                 usb_pkt_abort,
    input  logic                 usb_iso,
    input  logic [NUM_SLOTS-1:0] slot_valid,
    output logic                 wr_en,
    output slot_idx_t            wr_slot,
    output logic [ADR_W-1:0]     wr_addr,
    output logic [DATA_W-1:0]    wr_data,
    output logic                 commit,
    output slot_idx_t            commit_slot,
    output logic [CNT_W-1:0]     commit_len,
    output logic                 usb_nak,
    output logic                 usb_drop
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_BYTES);

    fill_state_e      st_q;
    slot_idx_t        wr_ptr_q;
    slot_idx_t        tgt_q;
    logic [CNT_W-1:0] cnt_q;
    logic             nak_q;
    logic             drop_q;

    slot_idx_t eff_wr;
    logic      slot_free;
    logic      in_recv;
    logic      do_abort;

    assign eff_wr    = dbl_en ? wr_ptr_q : slot_idx_t'(0);
    assign slot_free = !slot_valid[eff_wr];
    assign in_recv   = (st_q == FILL_RECV);
    assign do_abort  = in_recv && usb_pkt_abort && !usb_pkt_start;
    assign commit    = in_recv && usb_pkt_commit && !usb_pkt_start && !usb_pkt_abort;
    assign wr_en     = in_recv && usb_byte_valid && !usb_pkt_start && !usb_pkt_abort
                       && !usb_pkt_commit && (cnt_q < CAP);

    assign wr_slot     = tgt_q;
    assign wr_addr     = cnt_q[ADR_W-1:0];
    assign wr_data     = usb_byte;
    assign commit_slot = tgt_q;
    assign commit_len  = cnt_q;
    assign usb_nak     = nak_q;
    assign usb_drop    = drop_q;

    // Track packet reception: accept, restart, discard, commit, count bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= FILL_IDLE;
            wr_ptr_q <= '0;
            tgt_q    <= '0;
            cnt_q    <= '0;
        end else if (usb_pkt_start) begin
            cnt_q <= '0;
            if (slot_free) begin
                st_q  <= FILL_RECV;
                tgt_q <= eff_wr;
            end else begin
                st_q  <= FILL_IDLE;
            end
        end else if (do_abort) begin
            st_q <= FILL_IDLE;
        end else if (commit) begin
            st_q     <= FILL_IDLE;
            wr_ptr_q <= next_slot(dbl_en, tgt_q);
        end else if (wr_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Raise the one-cycle refusal notice, kind chosen by the endpoint type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nak_q  <= 1'b0;
            drop_q <= 1'b0;
        end else begin
            nak_q  <= usb_pkt_start && !slot_free && !usb_iso;
            drop_q <= usb_pkt_start && !slot_free && usb_iso;
        end
    end

    p_refuse_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        usb_pkt_start && !slot_free |=> (st_q == FILL_IDLE) && (usb_nak || usb_drop));

    p_abort_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        do_abort |=> (st_q == FILL_IDLE));

    p_commit_free_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !slot_valid[tgt_q]);

    p_count_cap_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);

endmodule

// File: rtl/usb_rxbuf_drain.sv
// CPU-side drain control: owns the slot occupancy, the presented slot, the
// read position, release (manual or automatic) and the interrupt pulse.
// Assumes cfg_dbl_buf only changes while the buffer is empty.
module usb_rxbuf_drain
    import usb_rxbuf_pkg::*;
#(
    parameter int MAX_BYTES = 64,
    parameter int DATA_W    = 8,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int ADR_W    = $clog2(MAX_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dbl_en,
    input  logic                 cfg_autoclear,
    input  logic                 cfg_irq_en,
    input  logic [CNT_W-1:0]     cfg_max_pkt,
    input  logic                 cpu_rd,
    input  logic                 cpu_clr_rdy,
    input  logic                 commit,
    input  slot_idx_t            commit_slot,
    input  logic [DATA_W-1:0]    slot_byte,
    input  logic [CNT_W-1:0]     slot_len,
    output logic [NUM_SLOTS-1:0] slot_valid,
    output slot_idx_t            rd_slot,
    output logic [ADR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 pkt_rdy,
    output logic [CNT_W-1:0]     pkt_cnt,
    output logic                 buf_full,
    output logic                 irq
);

    logic [NUM_SLOTS-1:0] valid_q;
    logic [NUM_SLOTS-1:0] valid_nxt;
    slot_idx_t            head_q;
    slot_idx_t            head_nxt;
    slot_idx_t            eff_head;
    logic [CNT_W-1:0]     rd_ptr_q;
    logic [CNT_W:0]       rd_ptr_inc;
    logic                 irq_q;
    logic                 pkt_rdy_w;
    logic                 have_byte;
    logic                 pop;
    logic                 auto_hit;
    logic                 release_w;
    logic                 rdy_nxt;

    assign eff_head   = dbl_en ? head_q : slot_idx_t'(0);
    assign pkt_rdy_w  = valid_q[eff_head];
    assign have_byte  = pkt_rdy_w && (rd_ptr_q < slot_len);
    assign pop        = cpu_rd && have_byte;
    assign rd_ptr_inc = {1'b0, rd_ptr_q} + 1'b1;
    assign auto_hit   = cfg_autoclear && pop && (rd_ptr_inc == {1'b0, cfg_max_pkt});
    assign release_w  = pkt_rdy_w && (cpu_clr_rdy || auto_hit);

    // Occupancy and presented slot after this cycle's release and commit.
    always_comb begin
        valid_nxt = valid_q;
        if (release_w) begin
            valid_nxt[eff_head] = 1'b0;
        end
        if (commit) begin
            valid_nxt[commit_slot] = 1'b1;
        end
        head_nxt = release_w ? next_slot(dbl_en, eff_head) : head_q;
        rdy_nxt  = valid_nxt[dbl_en ? head_nxt : slot_idx_t'(0)];
    end

    // Update occupancy, presented slot and read position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            head_q   <= '0;
            rd_ptr_q <= '0;
        end else begin
            valid_q <= valid_nxt;
            head_q  <= head_nxt;
            if (release_w) begin
                rd_ptr_q <= '0;
            end else if (pop) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
        end
    end

    // Pulse the interrupt when a packet becomes presented, fresh or refilled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= cfg_irq_en && rdy_nxt && (!pkt_rdy_w || release_w);
        end
    end

    assign slot_valid = valid_q;
    assign rd_slot    = eff_head;
    assign rd_addr    = rd_ptr_q[ADR_W-1:0];
    assign cpu_rdata  = have_byte ? slot_byte : '0;
    assign pkt_rdy    = pkt_rdy_w;
    assign pkt_cnt    = pkt_rdy_w ? slot_len : '0;
    assign buf_full   = &valid_q;
    assign irq        = irq_q;

    p_irq_needs_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pkt_rdy);

    p_rise_gives_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_rdy) && $past(cfg_irq_en) |-> irq);

    p_refill_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        release_w && (&valid_q) |=> pkt_rdy);

    p_refill_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        release_w && (&valid_q) && cfg_irq_en |=> irq);

    p_full_presents_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> pkt_rdy);

    p_read_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !release_w |=> rd_ptr_q == $past(rd_ptr_q) + 1'b1);

    p_past_end_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_rdy_w && cpu_rd && !have_byte && !release_w |=> $stable(rd_ptr_q));

    p_release_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        release_w |=> rd_ptr_q == '0);

endmodule

// File: rtl/usb_rxbuf.sv
// Top of the USB OUT endpoint receive buffer: one or two packet slots
// between the USB receive side and a CPU byte-read port.
// Assumes configuration inputs other than the interrupt enable are only
// changed while no packet is held or being received.
module usb_rxbuf
    import usb_rxbuf_pkg::*;
#(
    parameter int MAX_BYTES = 64,
    parameter int DATA_W    = 8,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int ADR_W    = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_pkt_start,
    input  logic              usb_byte_valid,
    input  logic [DATA_W-1:0] usb_byte,
    input  logic              usb_pkt_commit,
    input  logic              usb_pkt_abort,
    input  logic              usb_iso,
    output logic              usb_nak,
    output logic              usb_drop,
    input  logic              cfg_dbl_buf,
    input  logic              cfg_autoclear,
    input  logic              cfg_irq_en,
    input  logic [CNT_W-1:0]  cfg_max_pkt,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cpu_clr_rdy,
    output logic              pkt_rdy,
    output logic [CNT_W-1:0]  pkt_cnt,
    output logic              buf_full,
    output logic              irq
);

    logic                 wr_en;
    slot_idx_t            wr_slot;
    logic [ADR_W-1:0]     wr_addr;
    logic [DATA_W-1:0]    wr_data;
    logic                 commit;
    slot_idx_t            commit_slot;
    logic [CNT_W-1:0]     commit_len;
    logic [NUM_SLOTS-1:0] slot_valid;
    slot_idx_t            rd_slot;
    logic [ADR_W-1:0]     rd_addr;
    logic [DATA_W-1:0]    rd_byte;
    logic [CNT_W-1:0]     rd_len;

    usb_rxbuf_fill #(.MAX_BYTES(MAX_BYTES), .DATA_W(DATA_W)) u_fill (
        .clk            (clk),
        .rst_n          (rst_n),
        .dbl_en         (cfg_dbl_buf),
        .usb_pkt_start  (usb_pkt_start),
        .usb_byte_valid (usb_byte_valid),
        .usb_byte       (usb_byte),
        .usb_pkt_commit (usb_pkt_commit),
        .usb_pkt_abort  (usb_pkt_abort),
        .usb_iso        (usb_iso),
        .slot_valid     (slot_valid),
        .wr_en          (wr_en),
        .wr_slot        (wr_slot),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .commit         (commit),
        .commit_slot    (commit_slot),
        .commit_len     (commit_len),
        .usb_nak        (usb_nak),
        .usb_drop       (usb_drop)
    );

    usb_rxbuf_store #(.MAX_BYTES(MAX_BYTES), .DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_slot     (wr_slot),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .commit      (commit),
        .commit_slot (commit_slot),
        .commit_len  (commit_len),
        .rd_slot     (rd_slot),
        .rd_addr     (rd_addr),
        .rd_byte     (rd_byte),
        .rd_len      (rd_len)
    );

    usb_rxbuf_drain #(.MAX_BYTES(MAX_BYTES), .DATA_W(DATA_W)) u_drain (
        .clk           (clk),
        .rst_n         (rst_n),
        .dbl_en        (cfg_dbl_buf),
        .cfg_autoclear (cfg_autoclear),
        .cfg_irq_en    (cfg_irq_en),
        .cfg_max_pkt   (cfg_max_pkt),
        .cpu_rd        (cpu_rd),
        .cpu_clr_rdy   (cpu_clr_rdy),
        .commit        (commit),
        .commit_slot   (commit_slot),
        .slot_byte     (rd_byte),
        .slot_len      (rd_len),
        .slot_valid    (slot_valid),
        .rd_slot       (rd_slot),
        .rd_addr       (rd_addr),
        .cpu_rdata     (cpu_rdata),
        .pkt_rdy       (pkt_rdy),
        .pkt_cnt       (pkt_cnt),
        .buf_full      (buf_full),
        .irq           (irq)
    );

    p_single_never_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dbl_buf && !$past(cfg_dbl_buf) |-> !buf_full);

    p_drop_no_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        usb_drop |-> !usb_nak);

endmodule

// File: tb/test_usb_rxbuf.sv
// Bench: a behavioural model (byte queue plus length queue) is updated at
// every rising edge from the driven inputs and compared at every falling edge.
module test_usb_rxbuf;

    localparam int MAXB = 64;
    localparam int CW   = $clog2(MAXB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          usb_pkt_start = 1'b0;
    logic          usb_byte_valid = 1'b0;
    logic [7:0]    usb_byte = '0;
    logic          usb_pkt_commit = 1'b0;
    logic          usb_pkt_abort = 1'b0;
    logic          usb_iso = 1'b0;
    logic          usb_nak;
    logic          usb_drop;
    logic          cfg_dbl_buf = 1'b0;
    logic          cfg_autoclear = 1'b0;
    logic          cfg_irq_en = 1'b1;
    logic [CW-1:0] cfg_max_pkt = '0;
    logic          cpu_rd = 1'b0;
    logic [7:0]    cpu_rdata;
    logic          cpu_clr_rdy = 1'b0;
    logic          pkt_rdy;
    logic [CW-1:0] pkt_cnt;
    logic          buf_full;
    logic          irq;

    always #10 clk = ~clk;

    usb_rxbuf #(.MAX_BYTES(MAXB), .DATA_W(8)) i_usb_rxbuf (
        .clk(clk), .rst_n(rst_n),
        .usb_pkt_start(usb_pkt_start), .usb_byte_valid(usb_byte_valid),
        .usb_byte(usb_byte), .usb_pkt_commit(usb_pkt_commit),
        .usb_pkt_abort(usb_pkt_abort), .usb_iso(usb_iso),
        .usb_nak(usb_nak), .usb_drop(usb_drop),
        .cfg_dbl_buf(cfg_dbl_buf), .cfg_autoclear(cfg_autoclear),
        .cfg_irq_en(cfg_irq_en), .cfg_max_pkt(cfg_max_pkt),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_clr_rdy(cpu_clr_rdy),
        .pkt_rdy(pkt_rdy), .pkt_cnt(pkt_cnt), .buf_full(buf_full), .irq(irq)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string scen = "reset";

    // Reference model state.
    logic [7:0] m_bytes[$];
    int         m_lens[$];
    logic [7:0] m_cur[$];
    int         m_rdi = 0;
    bit         m_act = 0;
    bit         e_irq = 0, e_nak = 0, e_drop = 0;
    bit         was_rdy, rel;
    int         cap, stored;

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s (%s) actual=%0d expected=%0d", tag, nm, scen, act, exp);
        end
    endtask

    // Model update from the inputs seen at this rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_bytes.delete(); m_lens.delete(); m_cur.delete();
            m_rdi = 0; m_act = 0; e_irq = 0; e_nak = 0; e_drop = 0;
        end else begin
            was_rdy = (m_lens.size() > 0);
            stored  = m_lens.size();
            cap     = cfg_dbl_buf ? 2 : 1;
            rel     = 0;
            e_nak   = 0;
            e_drop  = 0;
            if (was_rdy) begin
                if (cpu_rd && m_rdi < m_lens[0]) begin
                    m_rdi++;
                    if (cfg_autoclear && m_rdi == int'(cfg_max_pkt)) rel = 1;
                end
                if (cpu_clr_rdy) rel = 1;
            end
            if (rel) begin
                repeat (m_lens[0]) void'(m_bytes.pop_front());
                void'(m_lens.pop_front());
                m_rdi = 0;
            end
            if (usb_pkt_start) begin
                if (stored < cap) begin
                    m_act = 1; m_cur.delete();
                end else begin
                    m_act = 0;
                    if (usb_iso) e_drop = 1; else e_nak = 1;
                end
            end else if (usb_pkt_abort) begin
                m_act = 0;
            end else if (usb_pkt_commit) begin
                if (m_act) begin
                    foreach (m_cur[i]) m_bytes.push_back(m_cur[i]);
                    m_lens.push_back(m_cur.size());
                end
                m_act = 0;
            end else if (usb_byte_valid && m_act && m_cur.size() < MAXB) begin
                m_cur.push_back(usb_byte);
            end
            e_irq = cfg_irq_en && (m_lens.size() > 0) && (!was_rdy || rel);
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit rdy = (m_lens.size() > 0);
            automatic int ecnt = rdy ? m_lens[0] : 0;
            automatic int edat = (rdy && m_rdi < ecnt) ? int'(m_bytes[m_rdi]) : 0;
            chk("R2", "pkt_rdy", int'(pkt_rdy), int'(rdy));
            chk("R2", "irq", int'(irq), int'(e_irq));
            chk("R3", "pkt_cnt", int'(pkt_cnt), ecnt);
            chk("R1", "cpu_rdata", int'(cpu_rdata), edat);
            chk("R6", "buf_full", int'(buf_full), int'(m_lens.size() == 2));
            chk("R9", "usb_nak", int'(usb_nak), int'(e_nak));
            chk("R8", "usb_drop", int'(usb_drop), int'(e_drop));
        end
    end

    task automatic cyc(input bit st = 0, input bit bv = 0, input logic [7:0] b = '0,
                       input bit cm = 0, input bit ab = 0, input bit rd = 0, input bit cl = 0);
        @(negedge clk);
        usb_pkt_start  = st;
        usb_byte_valid = bv;
        usb_byte       = b;
        usb_pkt_commit = cm;
        usb_pkt_abort  = ab;
        cpu_rd         = rd;
        cpu_clr_rdy    = cl;
    endtask

    task automatic send_pkt(input int n, input int base, input bit iso, input bit bad);
        usb_iso = iso;
        cyc(1);
        for (int i = 0; i < n; i++) cyc(0, 1, 8'(base + i * 7));
        cyc(0, 0, '0, !bad, bad);
        cyc();
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, 0, 1, 0);
        cyc();
    endtask

    task automatic clear_pkt;
        cyc(0, 0, '0, 0, 0, 0, 1);
        cyc();
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        scen = "reset";
        chk("R2", "reset pkt_rdy", int'(pkt_rdy), 0);
        chk("R3", "reset pkt_cnt", int'(pkt_cnt), 0);

        scen = "R1 R11 single packet, reads past end";
        send_pkt(5, 8'h11, 0, 0);
        chk("R3", "pkt_cnt", int'(pkt_cnt), 5);
        read_n(7);
        chk("R11", "cpu_rdata past end", int'(cpu_rdata), 0);
        scen = "R4 clear releases";
        clear_pkt();
        chk("R4", "pkt_rdy after clear", int'(pkt_rdy), 0);

        scen = "R12 single buffer refuses second";
        send_pkt(3, 8'h40, 0, 0);
        send_pkt(4, 8'h90, 0, 0);
        chk("R12", "pkt_cnt kept", int'(pkt_cnt), 3);
        send_pkt(4, 8'hA0, 1, 0);
        chk("R8", "pkt_cnt after drop", int'(pkt_cnt), 3);
        read_n(1);
        clear_pkt();

        scen = "R10 abort then good";
        send_pkt(6, 8'h20, 0, 1);
        chk("R10", "pkt_rdy after abort", int'(pkt_rdy), 0);
        usb_iso = 0;
        cyc(1); cyc(0, 1, 8'h55); cyc(1); cyc(0, 1, 8'h66); cyc(0, 0, '0, 1); cyc();
        chk("R10", "restart count", int'(pkt_cnt), 1);
        clear_pkt();

        scen = "R5 R6 double buffering";
        cfg_dbl_buf = 1;
        send_pkt(3, 8'h01, 0, 0);
        send_pkt(4, 8'h80, 0, 0);
        chk("R6", "buf_full", int'(buf_full), 1);
        send_pkt(2, 8'hC0, 0, 0);
        send_pkt(2, 8'hD0, 1, 0);
        read_n(2);
        cyc(0, 0, '0, 0, 0, 0, 1);
        cyc();
        chk("R5", "second presented", int'(pkt_cnt), 4);
        chk("R5", "fresh irq", int'(irq), 1);
        read_n(4);
        clear_pkt();

        scen = "R7 automatic release";
        cfg_autoclear = 1;
        cfg_max_pkt = CW'(4);
        send_pkt(6, 8'h30, 0, 0);
        send_pkt(5, 8'h70, 0, 0);
        read_n(4);
        chk("R7", "next after autoclear", int'(pkt_cnt), 5);
        read_n(4);
        chk("R7", "released again", int'(pkt_rdy), 0);
        send_pkt(3, 8'h50, 0, 0);
        read_n(5);
        chk("R7", "short stays", int'(pkt_rdy), 1);
        clear_pkt();
        cfg_autoclear = 0;

        scen = "R13 oversized packet";
        send_pkt(70, 8'h03, 0, 0);
        chk("R13", "capped count", int'(pkt_cnt), MAXB);
        read_n(MAXB + 2);
        clear_pkt();

        scen = "R2 interrupts disabled";
        cfg_irq_en = 0;
        send_pkt(2, 8'h09, 0, 0);
        chk("R2", "no irq", int'(irq), 0);
        clear_pkt();
        cfg_irq_en = 1;

        for (int ph = 0; ph < 2; ph++) begin
            scen = (ph == 0) ? "R5 random double" : "R12 random single";
            cfg_dbl_buf = (ph == 0);
            for (int k = 0; k < 300; k++) begin
                automatic int op = $urandom_range(0, 5);
                cfg_autoclear = $urandom_range(0, 3) == 0;
                cfg_max_pkt   = CW'($urandom_range(1, 10));
                cfg_irq_en    = $urandom_range(0, 4) != 0;
                if (op <= 1) send_pkt($urandom_range(0, 12), $urandom_range(0, 255),
                                      $urandom_range(0, 1), $urandom_range(0, 7) == 0);
                else if (op <= 3) read_n($urandom_range(1, 8));
                else if (op == 4) clear_pkt();
                else cyc();
            end
            cfg_autoclear = 0;
            repeat (4) clear_pkt();
        end

        finish_run();
    end

endmodule